// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block runs single write transactions on a PHY test-control port. The port has four parts: a test clock, a test enable, an 8-bit input byte bus toward the PHY, and an 8-bit output byte bus back from it. A host presents a register selector (the code) and a value byte, then pulses `start`. The sequencer then steps the port through a fixed order. The code is taken by the PHY on a falling test-clock edge while enable is high. The value byte is taken on the next rising edge while enable is low. Each step is held for a host-chosen number of system clocks, which gives setup and hold margin. After the last step the sequencer captures the PHY's returned byte and pulses `done`.

A second, independent path drives the PHY's test-clear line. On request, the line goes high for a chosen number of system clocks and then returns low. The two paths exclude each other, so the clear line never rises in the middle of a transaction, and no transaction starts while the clear line is high.

Sequencer states and transitions:
- SEQ_IDLE goes to SEQ_CODE on an accepted start.
- SEQ_CODE goes to SEQ_EN_HI.
- SEQ_EN_HI goes to SEQ_CLK_LO.
- SEQ_CLK_LO goes to SEQ_EN_LO.
- SEQ_EN_LO goes to SEQ_DATA.
- SEQ_DATA goes to SEQ_CLK_HI.
- SEQ_CLK_HI goes back to SEQ_IDLE, and this transition pulses `done`.

Each transition after SEQ_IDLE fires when the phase timer expires. The clear path has two states: CLR_IDLE goes to CLR_HOLD on an accepted request, and CLR_HOLD returns to CLR_IDLE when its timer expires.

Top module: `phy_test_seq`

## Requirements
- R1: After synchronous reset: `tst_clk`=1, `tst_en`=0, `tst_din`=0, `tst_clr`=0, `busy`=0, `done`=0 and `result`=0.
- R2: The code phase runs in this order. First `tst_din` takes the code while `tst_clk`=1 and `tst_en`=0. Next `tst_en` rises. Then `tst_clk` falls while `tst_en`=1 and the code is still on `tst_din`.
- R3: The data phase runs in this order. First `tst_en` falls. Next `tst_din` takes the data byte. Then `tst_clk` rises while `tst_en`=0.
- R4: At most one of `tst_clk`, `tst_en` and `tst_din` changes on any clock edge. Each of the six phases lasts exactly H system clocks. H is `hold_cycles`, sampled when start is accepted, and a value of 0 is treated as 1.
- R5: `done` is a one-cycle pulse. It comes 6H clocks after the edge that accepted start. In that same cycle `result` holds the value `tst_dout` had at that edge, and the value stays until the next transaction.
- R6: `busy` is high from the edge that accepts start until the edge that raises `done`. A start while busy has no effect on the port, the timing or the result.
- R7: A clear request accepted while both paths are idle drives `tst_clr` high for exactly `clr_cycles` clocks (0 is treated as 1), and then drives it low. If a clear request and a start arrive in the same cycle, the start wins. A clear request is ignored while a transaction is busy or a clear is running, and a start is ignored while a clear is running.
- R8: Between transactions `tst_clk` stays high, `tst_en` stays low and `tst_din` keeps the last data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a write transaction |
| code_in | input | DATA_W | Test code for the transaction |
| data_in | input | DATA_W | Data byte for the transaction |
| hold_cycles | input | HOLD_W | System clocks per phase (0 means 1) |
| clr_req | input | 1 | Request a test-clear pulse |
| clr_cycles | input | CLR_W | Clear pulse length in clocks (0 means 1) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | DATA_W | Captured PHY output byte |
| clr_busy | output | 1 | Clear pulse in progress |
| tst_clk | output | 1 | PHY test clock, idles high |
| tst_en | output | 1 | PHY test enable, marks the code phase |
| tst_din | output | DATA_W | Byte bus toward the PHY |
| tst_dout | input | DATA_W | Byte bus from the PHY |
| tst_clr | output | 1 | PHY test-clear line |

## Verification
The bench checks the port waveform cycle by cycle for hold values of 4, 3, 1 and 0. A design that ignored the zero-as-one rule would run its counter past the limit and stretch every phase. A design that switched enable and clock together would let the PHY model latch the wrong code, and this shows up in the returned byte. The bench also sends a start in the middle of a transaction, a clear request while a transaction is busy, a start while a clear is running, and a start and clear request in the same cycle. A design without the mutual exclusion would corrupt the port state or the clear pulse width, and the bench reports either one. The bench measures clear pulses of 5 clocks and of 0 (treated as 1), which catches off-by-one counting.

// File: rtl/pts_pkg.sv
package pts_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CODE,
        SEQ_EN_HI,
        SEQ_CLK_LO,
        SEQ_EN_LO,
        SEQ_DATA,
        SEQ_CLK_HI
    } seq_state_t;

    typedef enum logic {
        CLR_IDLE,
        CLR_HOLD
    } clr_state_t;

endpackage

// File: rtl/pts_timer.sv
module pts_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expire
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] last_cnt;

    // a limit of zero behaves as one cycle
    assign last_cnt = (limit == '0) ? '0 : limit - 1'b1;
    assign expire   = (cnt_q == last_cnt);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        !$past(restart) |-> cnt_q <= last_cnt) else $error("timer overrun"); // R4

endmodule

// File: rtl/pts_seq_fsm.sv
module pts_seq_fsm
    import pts_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              blocked,
    input  logic [DATA_W-1:0] code_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic [DATA_W-1:0] tst_dout,
    output logic              tst_clk,
    output logic              tst_en,
    output logic [DATA_W-1:0] tst_din,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    seq_state_t        state_q, state_d;
    logic              start_ok;
    logic              phase_end;
    logic              tmr_restart;
    logic [DATA_W-1:0] code_q, data_q;
    logic [HOLD_W-1:0] hold_q;

    assign start_ok    = start && (state_q == SEQ_IDLE) && !blocked;
    assign busy        = (state_q != SEQ_IDLE);
    assign tmr_restart = (state_q == SEQ_IDLE) || phase_end;

    pts_timer #(.W(HOLD_W)) u_phase_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (hold_q),
        .expire  (phase_end)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (start_ok)  state_d = SEQ_CODE;
            SEQ_CODE:   if (phase_end) state_d = SEQ_EN_HI;
            SEQ_EN_HI:  if (phase_end) state_d = SEQ_CLK_LO;
            SEQ_CLK_LO: if (phase_end) state_d = SEQ_EN_LO;
            SEQ_EN_LO:  if (phase_end) state_d = SEQ_DATA;
            SEQ_DATA:   if (phase_end) state_d = SEQ_CLK_HI;
            SEQ_CLK_HI: if (phase_end) state_d = SEQ_IDLE;
            default:                   state_d = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // operand capture
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            data_q <= '0;
            hold_q <= '0;
        end else if (start_ok) begin
            code_q <= code_in;
            data_q <= data_in;
            hold_q <= hold_cycles;
        end
    end

    // registered port outputs: one signal moves per phase entry
    always_ff @(posedge clk) begin
        if (rst) begin
            tst_clk <= 1'b1;
            tst_en  <= 1'b0;
            tst_din <= '0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            if (state_d != state_q) begin
                unique case (state_d)
                    SEQ_CODE:   tst_din <= code_in;
                    SEQ_EN_HI:  tst_en  <= 1'b1;
                    SEQ_CLK_LO: tst_clk <= 1'b0;
                    SEQ_EN_LO:  tst_en  <= 1'b0;
                    SEQ_DATA:   tst_din <= data_q;
                    SEQ_CLK_HI: tst_clk <= 1'b1;
                    SEQ_IDLE: begin
                        result <= tst_dout;
                        done   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_CODE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(tst_clk) |-> tst_en && tst_din == code_q) else $error("code edge"); // R2
    AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tst_clk) |-> !tst_en && tst_din == data_q) else $error("data edge"); // R3
    AST_ONE_CHANGE: assert property (@(posedge clk) disable iff (rst)
        $countones({tst_clk != $past(tst_clk), tst_en != $past(tst_en),
                    tst_din != $past(tst_din)}) <= 1) else $error("multi change"); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done width"); // R5
    AST_BUSY_START_IGN: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> code_q == $past(code_q)) else $error("start accepted while busy"); // R6
    AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tst_clk && !tst_en) else $error("idle port"); // R8

endmodule

// File: rtl/pts_clear.sv
module pts_clear
    import pts_pkg::*;
#(
    parameter int CLR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             blocked,
    input  logic [CLR_W-1:0] cycles,
    output logic             tst_clr,
    output logic             clr_busy
);

    clr_state_t       st_q, st_d;
    logic [CLR_W-1:0] cyc_q;
    logic             accept;
    logic             expire;
    logic             tmr_restart;

    assign accept      = req && (st_q == CLR_IDLE) && !blocked;
    assign clr_busy    = (st_q == CLR_HOLD);
    assign tmr_restart = (st_q == CLR_IDLE) || expire;

    pts_timer #(.W(CLR_W)) u_clr_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (cyc_q),
        .expire  (expire)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLR_IDLE: if (accept) st_d = CLR_HOLD;
            CLR_HOLD: if (expire) st_d = CLR_IDLE;
            default:              st_d = CLR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CLR_IDLE;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q   <= '0;
            tst_clr <= 1'b0;
        end else begin
            if (accept) cyc_q <= cycles;
            tst_clr <= (st_d == CLR_HOLD);
        end
    end

    AST_CLR_REQ_IGN: assert property (@(posedge clk) disable iff (rst)
        clr_busy && req |=> cyc_q == $past(cyc_q)) else $error("clear retriggered"); // R7
    AST_CLR_MATCH: assert property (@(posedge clk) disable iff (rst)
        tst_clr == clr_busy) else $error("clear line mismatch"); // R7

endmodule

// File: rtl/phy_test_seq.sv
module phy_test_seq #(
    parameter int DATA_W = 8,
    parameter int HOLD_W = 8,
    parameter int CLR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] code_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic [HOLD_W-1:0] hold_cycles,
    input  logic              clr_req,
    input  logic [CLR_W-1:0]  clr_cycles,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              clr_busy,
    output logic              tst_clk,
    output logic              tst_en,
    output logic [DATA_W-1:0] tst_din,
    input  logic [DATA_W-1:0] tst_dout,
    output logic              tst_clr
);

    logic clr_blocked;

    // start has priority over a clear request in the same cycle
    assign clr_blocked = busy || start;

    pts_seq_fsm #(.DATA_W(DATA_W), .HOLD_W(HOLD_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .blocked     (clr_busy),
        .code_in     (code_in),
        .data_in     (data_in),
        .hold_cycles (hold_cycles),
        .tst_dout    (tst_dout),
        .tst_clk     (tst_clk),
        .tst_en      (tst_en),
        .tst_din     (tst_din),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );

    pts_clear #(.CLR_W(CLR_W)) u_clr (
        .clk      (clk),
        .rst      (rst),
        .req      (clr_req),
        .blocked  (clr_blocked),
        .cycles   (clr_cycles),
        .tst_clr  (tst_clr),
        .clr_busy (clr_busy)
    );

    AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        tst_clr |-> !busy) else $error("clear during transaction"); // R7

endmodule

// File: tb/phy_test_seq_tb_top.sv
module phy_test_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] code_in = '0, data_in = '0;
    logic [7:0] hold_cycles = 8'd4;
    logic       clr_req = 1'b0;
    logic [15:0] clr_cycles = '0;
    logic       busy, done, clr_busy, tst_clk, tst_en, tst_clr;
    logic [7:0] result, tst_din, tst_dout;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    phy_test_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .code_in(code_in), .data_in(data_in),
        .hold_cycles(hold_cycles), .clr_req(clr_req), .clr_cycles(clr_cycles),
        .busy(busy), .done(done), .result(result), .clr_busy(clr_busy),
        .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din),
        .tst_dout(tst_dout), .tst_clr(tst_clr)
    );

    // PHY test-register model: code on falling edge with enable high,
    // data on rising edge with enable low; stores data xor code.
    logic [7:0] mdl_mem [256];
    logic [7:0] mdl_addr = '0;
    bit         mdl_on = 0;
    initial for (int i = 0; i < 256; i++) mdl_mem[i] = '0;
    always @(negedge tst_clk) if (mdl_on && tst_en) mdl_addr <= tst_din;
    always @(posedge tst_clk) if (mdl_on && !tst_en) mdl_mem[mdl_addr] <= tst_din ^ mdl_addr;
    assign tst_dout = mdl_mem[mdl_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // mode 0 plain, 1 extra start mid-way, 2 clear request mid-way
    task automatic run_txn(input logic [7:0] c, input logic [7:0] d,
                           input logic [7:0] h, input int mode);
        int he = (h == 0) ? 1 : h;
        bit seq_ok = 1, busy_ok = 1, clr_ok = 1;
        int bad_j = -1;
        @(negedge clk);
        code_in = c; data_in = d; hold_cycles = h; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < 6 * he; j++) begin
            int p = j / he;
            logic ec = (p < 2) || (p == 5);
            logic ee = (p == 1) || (p == 2);
            logic [7:0] ed = (p < 4) ? c : d;
            if (tst_clk !== ec || tst_en !== ee || tst_din !== ed) begin
                if (seq_ok) bad_j = j;
                seq_ok = 0;
            end
            if (busy !== 1'b1 || done !== 1'b0) busy_ok = 0;
            if (tst_clr !== 1'b0) clr_ok = 0;
            start   = (mode == 1) && (j == he);
            clr_req = (mode == 2) && (j == he);
            if (mode == 1 && j == he) code_in = c ^ 8'hFF;
            @(negedge clk);
            start = 1'b0; clr_req = 1'b0;
        end
        chk(seq_ok, "R2/R3/R4 phase order and length", bad_j, -1);
        chk(busy_ok, "R6 busy through transaction", busy, 1);
        chk(done === 1'b1 && busy === 1'b0, "R5 done at 6H", done, 1);
        chk(result === (c ^ d), "R5 result byte", result, c ^ d);
        if (mode == 1) chk(result === (c ^ d), "R6 start while busy ignored", result, c ^ d);
        if (mode == 2) chk(clr_ok && tst_clr === 1'b0, "R7 clear ignored while busy", tst_clr, 0);
        @(negedge clk);
        chk(done === 1'b0, "R5 done single cycle", done, 0);
        repeat (5) @(negedge clk);
        chk(tst_clk === 1'b1 && tst_en === 1'b0 && tst_din === d && !busy,
            "R8 idle holds port", tst_din, d);
    endtask

    // mode 0 plain, 1 start during the pulse
    task automatic run_clr(input logic [15:0] n, input int mode);
        int ne = (n == 0) ? 1 : n;
        int high = 0;
        bit contig = 1, seen_low = 0, port_ok = 1;
        logic [7:0] din0 = tst_din;
        @(negedge clk);
        clr_cycles = n; clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        chk(tst_clr === 1'b1, "R7 clear rises", tst_clr, 1);
        for (int j = 0; j < ne + 4; j++) begin
            if (tst_clr === 1'b1) begin
                high++;
                if (seen_low) contig = 0;
            end else seen_low = 1;
            if (busy !== 1'b0 || tst_clk !== 1'b1 || tst_din !== din0) port_ok = 0;
            start = (mode == 1) && (j == 0);
            if (start) code_in = 8'h5A;
            @(negedge clk);
            start = 1'b0;
        end
        chk(high == ne && contig, "R7 clear width", high, ne);
        if (mode == 1) chk(port_ok, "R7 start ignored while clearing", busy, 0);
    endtask

    task automatic run_both;
        @(negedge clk);
        code_in = 8'h21; data_in = 8'h43; hold_cycles = 8'd2;
        start = 1'b1; clr_req = 1'b1; clr_cycles = 16'd3;
        @(negedge clk);
        start = 1'b0; clr_req = 1'b0;
        chk(busy === 1'b1 && tst_clr === 1'b0, "R7 start wins over clear", tst_clr, 0);
        while (!done) @(negedge clk);
        chk(result === (8'h21 ^ 8'h43), "R5 result after tie", result, 8'h21 ^ 8'h43);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tst_clk === 1'b1 && tst_en === 1'b0 && tst_din === 8'h00 && tst_clr === 1'b0
            && busy === 1'b0 && done === 1'b0 && result === 8'h00,
            "R1 reset state", {tst_clk, tst_en, tst_clr, busy, done}, 5'b10000);
        rst = 1'b0;
        mdl_on = 1;
        repeat (2) @(negedge clk);
        run_txn(8'h44, 8'h2A, 8'd4, 0);
        run_txn(8'h17, 8'hC3, 8'd3, 0);
        run_txn(8'h18, 8'h01, 8'd1, 0);
        run_txn(8'hA5, 8'h5A, 8'd0, 0);
        run_txn(8'h3C, 8'h81, 8'd4, 1);
        run_txn(8'h19, 8'h7E, 8'd2, 2);
        run_clr(16'd5, 0);
        run_clr(16'd0, 0);
        run_clr(16'd6, 1);
        run_both();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule